// File: doc/BRIEF.md
# Monitor Byte Handshake Controller

This block moves message bytes across the monitor slot of a frame-multiplexed serial bus. Pacing comes from two active-low flag bits and not from the frame rate. One flag is driven by the side that transmits and marks a fresh byte. The other is driven by the side that receives and acknowledges that byte. The block sees a single strobe per frame, together with the monitor byte and both flags as sampled in that frame. It evaluates the handshake only on that strobe, so all of its bus-side outputs hold steady for a whole frame.

The host controls the transmit side directly. It loads a byte into a one-deep holding buffer and raises the transmit enable. The block then presents the byte with its data flag active until the far end acknowledges it, and signals an acknowledge pulse so the host can load the next byte. When the host drops the transmit enable between bytes, the message ends and the busy status clears. The far end can also abort the transfer. On the receive side, each fresh byte is captured, an interrupt is raised and the byte is acknowledged for exactly one frame. The block also detects the end of a message from the idle pattern of the data flag.

Top module: `mon_handshake`

## Requirements
- R1: `mx_out_n`, `mr_out_n`, `mon_tx_byte`, `xmit_busy` and `rx_rdata` change only at a clock edge where `frm_stb` is high. Flag inputs that change between strobes have no effect. Every interrupt output is a one-cycle pulse in the cycle after a strobe edge.
- R2: After reset, `mx_out_n` and `mr_out_n` are 1 (inactive), `mon_tx_byte` is all ones, `xmit_busy` is 0, `rx_rdata` is 0 and no interrupt is active.
- R3: A transfer starts at the first strobe where a byte is held in the buffer and `xmit_en` is 1. From that strobe on, `mx_out_n` is 0, `mon_tx_byte` equals the byte and `xmit_busy` is 1. A buffered byte with `xmit_en` at 0 starts nothing.
- R4: While the data flag is active, a strobe that samples `mr_in_n` at 0 when it was 1 at the previous strobe raises `irq_ack`. `mx_out_n` returns to 1 for at least the following frame.
- R5: After an acknowledge, if a new byte is buffered and `xmit_en` is 1 at the next strobe, that byte is sent with `mx_out_n` at 0. If no byte is buffered, `mx_out_n` stays 1 and `xmit_busy` stays 1.
- R6: If `xmit_en` is 0 at the strobe after an acknowledge, `mx_out_n` stays 1 and `xmit_busy` clears one strobe later.
- R7: While the data flag is active, `mr_in_n` sampled at 0 at two consecutive strobes is an abort. It raises `irq_abort` instead of `irq_ack`, drives `mx_out_n` to 1 and clears `xmit_busy` at that strobe.
- R8: With `recv_en` at 1, a strobe that samples `mx_in_n` at 0 after it was 1 at the previous strobe latches `mon_rx_byte` into `rx_rdata`, raises `irq_rx` and drives `mr_out_n` to 0 for exactly one frame.
- R9: `mx_in_n` held at 0 over consecutive strobes delivers no further byte: no `irq_rx`, and `rx_rdata` is unchanged.
- R10: With `recv_en` at 0, a fresh byte has no effect: no `irq_rx`, `rx_rdata` unchanged and `mr_out_n` stays 1.
- R11: After at least one received byte, `mx_in_n` sampled at 1 at two consecutive strobes raises `irq_eom` once. A single inactive frame between bytes raises nothing.
- R12: A host write during a transfer does not change `mon_tx_byte` until that byte has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_stb | input | 1 | One-cycle strobe, once per frame |
| mon_rx_byte | input | DW | Monitor byte received in this frame |
| mx_in_n | input | 1 | Far end's data flag, active low |
| mr_in_n | input | 1 | Far end's acknowledge flag, active low |
| mon_tx_byte | output | DW | Monitor byte to send, all ones when idle |
| mx_out_n | output | 1 | Own data flag, active low |
| mr_out_n | output | 1 | Own acknowledge flag, active low |
| tx_wr | input | 1 | Host write strobe for the transmit buffer |
| tx_wdata | input | DW | Host byte to send |
| xmit_en | input | 1 | Host transmit control |
| recv_en | input | 1 | Host receive control |
| xmit_busy | output | 1 | Transfer in progress |
| rx_rdata | output | DW | Last byte received |
| irq_ack | output | 1 | Byte acknowledged pulse |
| irq_rx | output | 1 | Byte received pulse |
| irq_eom | output | 1 | End of message pulse |
| irq_abort | output | 1 | Transfer aborted pulse |

## Verification
The checker watches several rules on every cycle. Outputs stay frozen between strobes. Every interrupt follows a strobe. Acknowledge and abort never fire together. An acknowledge is raised only for a byte that was actually on the bus. The sent byte does not change while the data flag stays active. The own acknowledge flag never lasts more than one frame, and the data flag is inactive whenever the transmitter is not busy. Only the directed scenarios can show that the right frame was chosen in each case: when a transfer starts, when the message closes after the enable drops, when a second active acknowledge counts as an abort, when a gap of one frame passes but two inactive frames close the message, and that a disabled receiver ignores a byte.

// File: rtl/mon_pkg.sv
// Shared types for the monitor handshake controller.
package mon_pkg;

    // Transmit-side sequence states.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_GAP  = 2'd2,
        TX_DONE = 2'd3
    } tx_state_t;

endpackage

// File: rtl/mon_tx.sv
// Transmit side of the monitor handshake.
// Holds one host byte, presents it with the data flag active until the
// far end acknowledges it with a fresh active acknowledge flag, then leaves
// one gap frame. An acknowledge flag seen active at two consecutive strobes
// while a byte is outstanding is an abort.
// Assumes stb is a single-cycle pulse per frame.
module mon_tx
    import mon_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          mr_in_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          en,
    output logic          mx_n,
    output logic [DW-1:0] byte_out,
    output logic          busy,
    output logic          ack_p,
    output logic          abort_p
);

    tx_state_t     state;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] out_q;
    logic          pend_q;
    logic          mr_last;
    logic          mr_now;

    assign mr_now = ~mr_in_n;

    // Sequence, buffer and pulse registers, advanced once per frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            hold_q  <= '0;
            out_q   <= '1;
            pend_q  <= 1'b0;
            mr_last <= 1'b0;
            ack_p   <= 1'b0;
            abort_p <= 1'b0;
        end else begin
            ack_p   <= 1'b0;
            abort_p <= 1'b0;
            if (stb) begin
                mr_last <= mr_now;
                unique case (state)
                    TX_IDLE: begin
                        if (en && pend_q) begin
                            state  <= TX_SEND;
                            out_q  <= hold_q;
                            pend_q <= 1'b0;
                        end
                    end
                    TX_SEND: begin
                        if (mr_now && mr_last) begin
                            state   <= TX_IDLE;
                            abort_p <= 1'b1;
                        end else if (mr_now) begin
                            state <= TX_GAP;
                            ack_p <= 1'b1;
                        end
                    end
                    TX_GAP: begin
                        if (!en) begin
                            state <= TX_DONE;
                        end else if (pend_q) begin
                            state  <= TX_SEND;
                            out_q  <= hold_q;
                            pend_q <= 1'b0;
                        end
                    end
                    TX_DONE: begin
                        state <= TX_IDLE;
                    end
                    default: state <= TX_IDLE;
                endcase
            end
            if (wr) begin
                hold_q <= wdata;
                pend_q <= 1'b1;
            end
        end
    end

    // Bus-side view of the sequence state.
    always_comb begin
        mx_n     = (state != TX_SEND);
        byte_out = (state == TX_SEND) ? out_q : '1;
        busy     = (state != TX_IDLE);
    end

endmodule

// File: rtl/mon_rx.sv
// Receive side of the monitor handshake.
// A byte is fresh when the far end's data flag is sampled active after
// being inactive at the previous strobe. A fresh byte is latched and
// acknowledged for one frame. Once a message has started, IDLE_FRAMES
// consecutive inactive samples of the data flag close it.
// Assumes stb is a single-cycle pulse per frame.
module mon_rx #(
    parameter int DW          = 8,
    parameter int IDLE_FRAMES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          mx_in_n,
    input  logic [DW-1:0] data_in,
    input  logic          en,
    output logic          mr_n,
    output logic [DW-1:0] rdata,
    output logic          rx_p,
    output logic          eom_p
);

    localparam int CW = $clog2(IDLE_FRAMES + 1);

    logic          mx_last;
    logic          mr_act;
    logic          in_msg;
    logic [CW-1:0] idle_cnt;
    logic          mx_now;

    assign mx_now = ~mx_in_n;
    assign mr_n   = ~mr_act;

    // Edge detect, latch, one-frame acknowledge and idle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mx_last  <= 1'b0;
            mr_act   <= 1'b0;
            in_msg   <= 1'b0;
            idle_cnt <= '0;
            rdata    <= '0;
            rx_p     <= 1'b0;
            eom_p    <= 1'b0;
        end else begin
            rx_p  <= 1'b0;
            eom_p <= 1'b0;
            if (stb) begin
                mx_last <= mx_now;
                mr_act  <= 1'b0;
                if (en && mx_now && !mx_last) begin
                    rdata    <= data_in;
                    rx_p     <= 1'b1;
                    mr_act   <= 1'b1;
                    in_msg   <= 1'b1;
                    idle_cnt <= '0;
                end else if (mx_now) begin
                    idle_cnt <= '0;
                end else if (in_msg) begin
                    if (idle_cnt == CW'(IDLE_FRAMES - 1)) begin
                        eom_p    <= 1'b1;
                        in_msg   <= 1'b0;
                        idle_cnt <= '0;
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mon_handshake.sv
// Monitor byte handshake controller, master operation.
// Joins the transmit side (host byte out, far-end acknowledge in) and the
// receive side (far-end byte in, own acknowledge out). Assumes one strobe
// per frame, with the sampled monitor byte and flags valid on that strobe.
module mon_handshake #(
    parameter int DW          = 8,
    parameter int IDLE_FRAMES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_stb,
    input  logic [DW-1:0] mon_rx_byte,
    input  logic          mx_in_n,
    input  logic          mr_in_n,
    output logic [DW-1:0] mon_tx_byte,
    output logic          mx_out_n,
    output logic          mr_out_n,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    input  logic          xmit_en,
    input  logic          recv_en,
    output logic          xmit_busy,
    output logic [DW-1:0] rx_rdata,
    output logic          irq_ack,
    output logic          irq_rx,
    output logic          irq_eom,
    output logic          irq_abort
);

    mon_tx #(.DW(DW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (frm_stb),
        .mr_in_n  (mr_in_n),
        .wr       (tx_wr),
        .wdata    (tx_wdata),
        .en       (xmit_en),
        .mx_n     (mx_out_n),
        .byte_out (mon_tx_byte),
        .busy     (xmit_busy),
        .ack_p    (irq_ack),
        .abort_p  (irq_abort)
    );

    mon_rx #(.DW(DW), .IDLE_FRAMES(IDLE_FRAMES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (frm_stb),
        .mx_in_n (mx_in_n),
        .data_in (mon_rx_byte),
        .en      (recv_en),
        .mr_n    (mr_out_n),
        .rdata   (rx_rdata),
        .rx_p    (irq_rx),
        .eom_p   (irq_eom)
    );

endmodule

// File: rtl/mon_handshake_chk.sv
// Checker for the monitor handshake controller, bound to its top.
module mon_handshake_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frm_stb,
    input logic          mr_in_n,
    input logic [DW-1:0] mon_tx_byte,
    input logic          mx_out_n,
    input logic          mr_out_n,
    input logic          xmit_busy,
    input logic [DW-1:0] rx_rdata,
    input logic          irq_ack,
    input logic          irq_rx,
    input logic          irq_eom,
    input logic          irq_abort
);

    AST_FROZEN_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> ($stable(mx_out_n) && $stable(mr_out_n) && $stable(mon_tx_byte)
                      && $stable(xmit_busy) && $stable(rx_rdata))); // R1

    AST_IRQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack || irq_rx || irq_eom || irq_abort) |-> $past(frm_stb)); // R1

    AST_IDLE_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !xmit_busy |-> mx_out_n); // R3

    AST_ACK_FOR_SENT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ($past(!mx_out_n) && $past(!mr_in_n) && mx_out_n)); // R4

    AST_ACK_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_ack, irq_abort})); // R7

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_abort |-> (mx_out_n && !xmit_busy)); // R7

    AST_OWN_ACK_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_out_n && frm_stb) |=> mr_out_n); // R8

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mx_out_n && !$past(mx_out_n)) |-> (mon_tx_byte == $past(mon_tx_byte))); // R12

    AST_EOM_NOT_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_eom && irq_rx)); // R11

endmodule

bind mon_handshake mon_handshake_chk #(.DW(DW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_stb     (frm_stb),
    .mr_in_n     (mr_in_n),
    .mon_tx_byte (mon_tx_byte),
    .mx_out_n    (mx_out_n),
    .mr_out_n    (mr_out_n),
    .xmit_busy   (xmit_busy),
    .rx_rdata    (rx_rdata),
    .irq_ack     (irq_ack),
    .irq_rx      (irq_rx),
    .irq_eom     (irq_eom),
    .irq_abort   (irq_abort)
);

// File: tb/test_mon_handshake.sv
module test_mon_handshake;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frm_stb = 1'b0;
    logic [DW-1:0] mon_rx_byte = '0;
    logic          mx_in_n = 1'b1;
    logic          mr_in_n = 1'b1;
    logic [DW-1:0] mon_tx_byte;
    logic          mx_out_n;
    logic          mr_out_n;
    logic          tx_wr = 1'b0;
    logic [DW-1:0] tx_wdata = '0;
    logic          xmit_en = 1'b0;
    logic          recv_en = 1'b0;
    logic          xmit_busy;
    logic [DW-1:0] rx_rdata;
    logic          irq_ack;
    logic          irq_rx;
    logic          irq_eom;
    logic          irq_abort;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic c_ack, c_rx, c_eom, c_abt;

    always #4 clk = ~clk;

    mon_handshake #(.DW(DW)) i_mon_handshake (
        .clk (clk), .rst_n (rst_n), .frm_stb (frm_stb),
        .mon_rx_byte (mon_rx_byte), .mx_in_n (mx_in_n), .mr_in_n (mr_in_n),
        .mon_tx_byte (mon_tx_byte), .mx_out_n (mx_out_n), .mr_out_n (mr_out_n),
        .tx_wr (tx_wr), .tx_wdata (tx_wdata), .xmit_en (xmit_en), .recv_en (recv_en),
        .xmit_busy (xmit_busy), .rx_rdata (rx_rdata),
        .irq_ack (irq_ack), .irq_rx (irq_rx), .irq_eom (irq_eom), .irq_abort (irq_abort)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One frame: drive sampled bus values, pulse the strobe, capture pulses.
    task automatic frame(input logic mxn, input logic mrn, input logic [DW-1:0] b);
        @(negedge clk);
        mx_in_n = mxn; mr_in_n = mrn; mon_rx_byte = b; frm_stb = 1'b1;
        @(negedge clk);
        frm_stb = 1'b0;
        c_ack = irq_ack; c_rx = irq_rx; c_eom = irq_eom; c_abt = irq_abort;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [DW-1:0] b);
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2 mx_out_n", 32'(mx_out_n), 1);
        chk("R2 mr_out_n", 32'(mr_out_n), 1);
        chk("R2 mon_tx_byte", 32'(mon_tx_byte), 32'hFF);
        chk("R2 busy", 32'(xmit_busy), 0);
        chk("R2 rx_rdata", 32'(rx_rdata), 0);
        chk("R2 irqs", 32'({irq_ack, irq_rx, irq_eom, irq_abort}), 0);
    endtask

    task automatic t_no_strobe;
        recv_en = 1'b1;
        @(negedge clk); mx_in_n = 1'b0; mr_in_n = 1'b0; mon_rx_byte = 8'h99;
        repeat (4) @(negedge clk);
        chk("R1 no strobe rx", 32'({irq_rx, mr_out_n}), 32'b01);
        chk("R1 no strobe rdata", 32'(rx_rdata), 0);
        mx_in_n = 1'b1; mr_in_n = 1'b1;
        recv_en = 1'b0;
    endtask

    task automatic t_send_and_end;
        host_write(8'hA5);
        frame(1, 1, 0);
        chk("R3 no start without enable", 32'({mx_out_n, xmit_busy}), 32'b10);
        xmit_en = 1'b1;
        frame(1, 1, 0);
        chk("R3 start flag", 32'(mx_out_n), 0);
        chk("R3 start byte", 32'(mon_tx_byte), 32'hA5);
        chk("R3 busy", 32'(xmit_busy), 1);
        frame(1, 1, 0);
        chk("R4 no ack while MR idle", 32'({c_ack, mx_out_n}), 0);
        host_write(8'h3C);
        chk("R12 byte held", 32'(mon_tx_byte), 32'hA5);
        frame(1, 0, 0);
        chk("R4 ack pulse", 32'(c_ack), 1);
        chk("R4 flag released", 32'(mx_out_n), 1);
        frame(1, 1, 0);
        chk("R5 next byte flag", 32'(mx_out_n), 0);
        chk("R5 next byte", 32'(mon_tx_byte), 32'h3C);
        frame(1, 1, 0);
        frame(1, 0, 0);
        chk("R4 second ack", 32'(c_ack), 1);
        xmit_en = 1'b0;
        frame(1, 1, 0);
        chk("R6 closing frame", 32'({mx_out_n, xmit_busy}), 32'b11);
        frame(1, 1, 0);
        chk("R6 busy cleared", 32'(xmit_busy), 0);
    endtask

    task automatic t_gap_and_abort;
        host_write(8'h11);
        xmit_en = 1'b1;
        frame(1, 1, 0);
        chk("R3 restart", 32'(mon_tx_byte), 32'h11);
        frame(1, 0, 0);
        chk("R4 ack", 32'(c_ack), 1);
        frame(1, 1, 0);
        chk("R5 no byte holds flag off", 32'({mx_out_n, xmit_busy}), 32'b11);
        host_write(8'h22);
        frame(1, 0, 0);
        chk("R5 late byte sent", 32'({mx_out_n, mon_tx_byte}), 32'h022);
        frame(1, 0, 0);
        chk("R7 abort pulse", 32'({c_abt, c_ack}), 32'b10);
        chk("R7 released", 32'({mx_out_n, xmit_busy}), 32'b10);
        xmit_en = 1'b0;
        frame(1, 1, 0);
    endtask

    task automatic t_receive;
        frame(1, 1, 0);
        frame(0, 1, 8'h77);
        chk("R10 disabled no irq", 32'(c_rx), 0);
        chk("R10 disabled no ack", 32'(mr_out_n), 1);
        chk("R10 disabled rdata", 32'(rx_rdata), 0);
        frame(1, 1, 0);
        recv_en = 1'b1;
        frame(0, 1, 8'h5A);
        chk("R8 irq_rx", 32'(c_rx), 1);
        chk("R8 rdata", 32'(rx_rdata), 32'h5A);
        chk("R8 ack active", 32'(mr_out_n), 0);
        frame(0, 1, 8'h66);
        chk("R9 held flag no new byte", 32'({c_rx, rx_rdata}), 32'h05A);
        chk("R8 ack one frame", 32'(mr_out_n), 1);
        frame(1, 1, 0);
        chk("R11 single gap no eom", 32'(c_eom), 0);
        frame(0, 1, 8'hC3);
        chk("R8 second byte", 32'({c_rx, rx_rdata}), 32'h1C3);
        frame(1, 1, 0);
        chk("R11 first idle no eom", 32'(c_eom), 0);
        frame(1, 1, 0);
        chk("R11 eom", 32'(c_eom), 1);
        frame(1, 1, 0);
        chk("R11 eom once", 32'(c_eom), 0);
        recv_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_strobe();
        t_send_and_end();
        t_gap_and_abort();
        t_receive();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule